// File: doc/BRIEF.md
# 100 Mb/s Receive PCS with Raw-Group Bypass

This block is the digital back end of a Fast Ethernet receiver. It takes one sliced, retimed three-level line symbol per bit clock. It turns level changes back into NRZ bits and strips the 11-bit self-synchronising scrambler. It then hunts for the start-of-stream delimiter to fix the 5-bit code-group boundary, and translates each following group into a 4-bit nibble. Nibbles leave on an MII-style receive group (data, valid, error) with a one-clock strobe, because the block runs on the bit clock and delivers one nibble every five bits.

The descrambler locks without help. While unlocked it loads its register from the received bits, assuming the line carries idle. It declares lock once a long run of descrambled ones appears, and it drops lock when no such run has been seen for a programmable number of bit periods. Losing lock closes any open frame.

A bypass input skips descrambling and decoding. In that mode every five line bits come out unchanged as a raw group on the error and data pins, and the valid pin stays low.

Top module: `fe_rx_pcs`

## Requirements
- R1: `mlt_i` encodes the line level as 2'b00 = zero, 2'b01 = plus, 2'b11 = minus. A line bit is 1 when `mlt_i` differs from its value in the previous bit period and 0 when it is unchanged. The level before the first period counts as zero.
- R2: Descrambled bit = line bit XOR (s[10] XOR s[8]) of the 11-bit register, which then shifts left taking in that key bit. While unlocked, the register instead takes in the inverted line bit. `locked_o` rises once ONES_MIN (30) consecutive descrambled ones have been seen, and not before.
- R3: While locked, `locked_o` falls after LOCK_WIN (1024) bit periods pass without a completed run of ONES_MIN ones. `rx_dv_o` goes low one clock later.
- R4: While locked and outside a frame, the descrambled stream is searched at every bit position for the pair 11000 10001 (first received bit leftmost). A match fixes the group boundary and produces one strobe with `rx_dv_o`=1, `rx_er_o`=0, `rxd_o`=4'b0101.
- R5: Inside a frame, each following 5-bit group is decoded and strobed with `rx_dv_o`=1, `rx_er_o`=0. The codes for nibbles 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: Inside a frame, a group that is neither a data code nor 01101 is strobed with `rx_dv_o`=1, `rx_er_o`=1, `rxd_o`=4'b0000, and the frame continues.
- R7: The group 01101 followed by 00111 ends the frame. Neither group is strobed, and `rx_dv_o` is low afterwards.
- R8: The group 01101 followed by any group other than 00111 yields a single strobe with `rx_dv_o`=1, `rx_er_o`=1, `rxd_o`=4'b0000. The frame then ends and the search of R4 resumes.
- R9: With `bypass_i` high, every fifth bit period strobes the last five raw line bits on {`rx_er_o`, `rxd_o`}, oldest bit as MSB, with `rx_dv_o` low. A line bit sampled at clock edge k is the LSB of a group that appears after edge k+2.
- R10: `rx_stb_o` is high for single clocks only, at most one clock in five. In normal mode it pulses only for nibbles of R4, R5, R6 and R8, and every such pulse carries `rx_dv_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | Raw 5-bit group output mode |
| mlt_i | input | 2 | Sliced line level: 00 zero, 01 plus, 11 minus |
| locked_o | output | 1 | Descrambler lock |
| rx_stb_o | output | 1 | One-clock strobe per output nibble or group |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error; group MSB in bypass |
| rxd_o | output | 4 | Receive nibble; group low bits in bypass |

## Verification
A descrambler register out of step with the line shows as soon as the next frame starts. The delimiter search fails and no strobe appears, or decoded nibbles come out wrong or flagged as errors, so comparing the whole nibble list of each frame exposes it within one frame. A stale group phase or frame flag shows as a strobe count that differs from the expected one, or as a nibble strobe outside a frame during the following idle. Lock faults surface at two fixed points: a lock that comes too early is caught 20 bits after reset, and a window that never expires is caught one window into a dead line.

// File: rtl/fe_rx_pcs_pkg.sv
package fe_rx_pcs_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;

  localparam logic [GRP_W-1:0] CG_SSD1 = 5'b11000;
  localparam logic [GRP_W-1:0] CG_SSD2 = 5'b10001;
  localparam logic [GRP_W-1:0] CG_ESD1 = 5'b01101;
  localparam logic [GRP_W-1:0] CG_ESD2 = 5'b00111;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  function automatic dec_t dec_grp(input logic [GRP_W-1:0] g);
    dec_t d;
    d.ok = 1'b1;
    unique case (g)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.ok  = 1'b0;
        d.nib = 4'h0;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fe_rx_pcs_lvl.sv
module fe_rx_pcs_lvl #(
  parameter int LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             bit_o
);
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      bit_o <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      bit_o <= (lvl_i != lvl_q);
    end
  end

  AST_STEADY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(lvl_i) && $past(rst_ni) && $stable(lvl_q) |=> !bit_o); // R1
endmodule

// File: rtl/fe_rx_pcs_dscr.sv
module fe_rx_pcs_dscr #(
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9,
  parameter int ONES_MIN = 30,
  parameter int LOCK_WIN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic raw_o,
  output logic plain_o,
  output logic locked_o
);
  localparam int RUN_W = $clog2(ONES_MIN + 1);
  localparam int WIN_W = $clog2(LOCK_WIN + 1);

  logic [LFSR_W-1:0] lfsr_q;
  logic [RUN_W-1:0]  run_q;
  logic [WIN_W-1:0]  win_q;
  logic              key, plain, run_ok;

  assign key    = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1];
  assign plain  = bit_i ^ key;
  assign run_ok = (run_q == RUN_W'(ONES_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q   <= '0;
      run_q    <= '0;
      win_q    <= '0;
      locked_o <= 1'b0;
      raw_o    <= 1'b0;
      plain_o  <= 1'b0;
    end else begin
      raw_o   <= bit_i;
      plain_o <= plain;
      // unlocked: assume idle (all ones) and track the line
      lfsr_q  <= {lfsr_q[LFSR_W-2:0], locked_o ? key : ~bit_i};
      if (!plain)       run_q <= '0;
      else if (!run_ok) run_q <= run_q + 1'b1;
      if (!locked_o) begin
        win_q <= '0;
        if (run_ok) locked_o <= 1'b1;
      end else if (run_ok) begin
        win_q <= '0;
      end else if (win_q == WIN_W'(LOCK_WIN - 1)) begin
        win_q    <= '0;
        locked_o <= 1'b0;
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end

  AST_LOCK_AFTER_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(plain_o)); // R2
  AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(ONES_MIN)); // R2
  AST_UNLOCK_AT_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(win_q) == WIN_W'(LOCK_WIN - 1)); // R3
endmodule

// File: rtl/fe_rx_pcs_frm.sv
module fe_rx_pcs_frm
  import fe_rx_pcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic             raw_i,
  input  logic             plain_i,
  input  logic             locked_i,
  output logic             rx_stb_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  localparam int SH_W  = 2 * GRP_W;
  localparam int PH_W  = $clog2(GRP_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

  logic [SH_W-1:0]  sh_q, sh_nx;
  logic [PH_W-1:0]  ph_q;
  logic             in_frm_q, esd1_q, edge_grp;
  logic [GRP_W-1:0] grp;
  dec_t             dec;

  assign sh_nx    = {sh_q[SH_W-2:0], bypass_i ? raw_i : plain_i};
  assign grp      = sh_nx[GRP_W-1:0];
  assign edge_grp = (ph_q == PH_LAST);
  assign dec      = dec_grp(grp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      ph_q     <= '0;
      in_frm_q <= 1'b0;
      esd1_q   <= 1'b0;
      rx_stb_o <= 1'b0;
      rx_dv_o  <= 1'b0;
      rx_er_o  <= 1'b0;
      rxd_o    <= '0;
    end else begin
      sh_q     <= sh_nx;
      rx_stb_o <= 1'b0;
      ph_q     <= edge_grp ? '0 : ph_q + 1'b1;
      if (bypass_i) begin
        in_frm_q <= 1'b0;
        esd1_q   <= 1'b0;
        rx_dv_o  <= 1'b0;
        if (edge_grp) begin
          {rx_er_o, rxd_o} <= grp;
          rx_stb_o         <= 1'b1;
        end
      end else if (!locked_i) begin
        in_frm_q <= 1'b0;
        esd1_q   <= 1'b0;
        rx_dv_o  <= 1'b0;
        rx_er_o  <= 1'b0;
      end else if (!in_frm_q) begin
        rx_dv_o <= 1'b0;
        rx_er_o <= 1'b0;
        if (sh_nx == {CG_SSD1, CG_SSD2}) begin
          in_frm_q <= 1'b1;
          ph_q     <= '0;
          rx_stb_o <= 1'b1;
          rx_dv_o  <= 1'b1;
          rxd_o    <= NIB_PRE;
        end
      end else if (edge_grp) begin
        if (esd1_q) begin
          esd1_q   <= 1'b0;
          in_frm_q <= 1'b0;
          if (grp == CG_ESD2) begin
            rx_dv_o <= 1'b0;
            rx_er_o <= 1'b0;
          end else begin
            rx_stb_o <= 1'b1;
            rx_dv_o  <= 1'b1;
            rx_er_o  <= 1'b1;
            rxd_o    <= '0;
          end
        end else if (grp == CG_ESD1) begin
          esd1_q <= 1'b1;
        end else begin
          rx_stb_o <= 1'b1;
          rx_dv_o  <= 1'b1;
          rx_er_o  <= ~dec.ok;
          rxd_o    <= dec.nib;
        end
      end
    end
  end

  AST_BYP_NO_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> !rx_dv_o); // R9
  AST_LOSS_DROPS_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> !rx_dv_o); // R3
  AST_STB_HAS_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_o && !$past(bypass_i) |-> rx_dv_o); // R10
  AST_ESD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frm_q && !bypass_i && edge_grp && !esd1_q && grp == CG_ESD1 |=> !rx_stb_o); // R7
endmodule

// File: rtl/fe_rx_pcs.sv
module fe_rx_pcs
  import fe_rx_pcs_pkg::*;
#(
  parameter int ONES_MIN = 30,
  parameter int LOCK_WIN = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bypass_i,
  input  logic [1:0] mlt_i,
  output logic       locked_o,
  output logic       rx_stb_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic [3:0] rxd_o
);
  logic line_bit, raw_bit, plain_bit;

  fe_rx_pcs_lvl #(.LVL_W(2)) u_lvl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (mlt_i),
    .bit_o (line_bit)
  );

  fe_rx_pcs_dscr #(
    .LFSR_W  (11),
    .LFSR_TAP(9),
    .ONES_MIN(ONES_MIN),
    .LOCK_WIN(LOCK_WIN)
  ) u_dscr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (line_bit),
    .raw_o   (raw_bit),
    .plain_o (plain_bit),
    .locked_o(locked_o)
  );

  fe_rx_pcs_frm u_frm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bypass_i(bypass_i),
    .raw_i   (raw_bit),
    .plain_i (plain_bit),
    .locked_i(locked_o),
    .rx_stb_o(rx_stb_o),
    .rx_dv_o (rx_dv_o),
    .rx_er_o (rx_er_o),
    .rxd_o   (rxd_o)
  );
endmodule

// File: tb/fe_rx_pcs_test.sv
`timescale 1ns/1ps
module fe_rx_pcs_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bypass = 1'b0;
  logic [1:0] mlt = 2'b00;
  logic       locked, stb, dv, er;
  logic [3:0] rxd;

  fe_rx_pcs uut (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_i(bypass), .mlt_i(mlt),
    .locked_o(locked), .rx_stb_o(stb), .rx_dv_o(dv), .rx_er_o(er), .rxd_o(rxd)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [10:0] scr = 11'h5A3;
  int          lvl_idx = 0;
  logic [1:0]  last_lv = 2'b00;
  logic [7:0]  hist = '0;
  bit          prev_stb = 1'b0;
  bit          mode_byp = 1'b0;
  int          byp_skip = 0, byp_cnt = 0;
  logic [5:0]  got [64];
  logic [5:0]  expq[64];
  int          got_n = 0, exp_n = 0;
  logic [3:0]  dat [32];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  function automatic logic [1:0] lvmap(input int i);
    case (i)
      1: lvmap = 2'b01;
      3: lvmap = 2'b11;
      default: lvmap = 2'b00;
    endcase
  endfunction

  task automatic monitor();
    if (stb) begin
      if (prev_stb) chk(1'b0, "R10 strobe width", 1, 0);
      if (mode_byp) begin
        if (byp_skip == 0) begin
          chk({er, rxd} == hist[6:2], "R9 raw group", int'({er, rxd}), int'(hist[6:2]));
          chk(!dv, "R9 dv low", int'(dv), 0);
          byp_cnt++;
        end
      end else begin
        if (got_n < 64) got[got_n] = {dv, er, rxd};
        got_n++;
      end
    end
    prev_stb = stb;
    if (byp_skip > 0) byp_skip--;
  endtask

  task automatic step(input logic [1:0] lv);
    @(negedge clk);
    monitor();
    mlt = lv;
    hist = {hist[6:0], (lv != last_lv)};
    last_lv = lv;
  endtask

  task automatic line(input logic c);
    if (c) lvl_idx = (lvl_idx + 1) % 4;
    step(lvmap(lvl_idx));
  endtask

  task automatic send_bit(input logic p);
    logic k;
    k = scr[10] ^ scr[8];
    scr = {scr[9:0], k};
    line(p ^ k);
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic push_exp(input logic [5:0] v);
    expq[exp_n] = v;
    exp_n++;
  endtask

  // bad_at: index replaced by 00000; esd_bad: T followed by idle instead of R
  task automatic run_frame(input int n, input int bad_at, input bit esd_bad, input string req);
    got_n = 0; exp_n = 0;
    idle(40);
    send_grp(5'b11000); send_grp(5'b10001);
    push_exp({2'b10, 4'b0101});
    for (int i = 0; i < n; i++) begin
      if (i == bad_at) begin
        send_grp(5'b00000); push_exp(6'b110000);
      end else begin
        send_grp(enc(dat[i])); push_exp({2'b10, dat[i]});
      end
    end
    send_grp(5'b01101);
    if (esd_bad) begin
      send_grp(5'b11111); push_exp(6'b110000);
    end else begin
      send_grp(5'b00111);
    end
    idle(40);
    chk(got_n == exp_n, {req, " nibble count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++)
      chk(got[i] == expq[i], {req, " nibble"}, int'(got[i]), int'(expq[i]));
    chk(!dv, {req, " dv low after frame"}, int'(dv), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    chk(!stb && !dv && !er && rxd == 4'h0, "R10 reset outputs", int'({stb, dv, er, rxd}), 0);
    chk(!locked, "R2 unlocked at reset", int'(locked), 0);

    idle(20);
    chk(!locked, "R2 no lock before run", int'(locked), 0);
    idle(200);
    chk(locked, "R2 lock on idle", int'(locked), 1);

    for (int i = 0; i < 16; i++) dat[i] = 4'(i);
    run_frame(16, -1, 1'b0, "R5 R7 all nibbles");
    for (int i = 0; i < 10; i++) dat[i] = 4'(15 - i);
    run_frame(10, 4, 1'b0, "R6 invalid group");
    for (int i = 0; i < 6; i++) dat[i] = 4'((i * 7) % 16);
    run_frame(6, -1, 1'b1, "R8 T without R");
    for (int i = 0; i < 3; i++) dat[i] = 4'(i + 9);
    run_frame(3, -1, 1'b0, "R4 short frame");

    // lock loss mid-frame: line goes quiet
    idle(40);
    send_grp(5'b11000); send_grp(5'b10001);
    send_grp(enc(4'h3)); send_grp(enc(4'hC));
    for (int i = 0; i < 512; i++) line(1'b0);
    chk(locked, "R3 lock held inside window", int'(locked), 1);
    for (int i = 0; i < 600; i++) line(1'b0);
    chk(!locked, "R3 lock lost", int'(locked), 0);
    chk(!dv, "R3 dv dropped", int'(dv), 0);

    idle(200);
    chk(locked, "R2 relock", int'(locked), 1);
    for (int i = 0; i < 8; i++) dat[i] = 4'((i * 5 + 2) % 16);
    run_frame(8, -1, 1'b0, "R5 after relock");

    // bypass: random levels, every group checked against line history (R1 R9)
    mode_byp = 1'b1;
    byp_skip = 10;
    bypass = 1'b1;
    begin
      logic [15:0] prng = 16'hACE1;
      for (int i = 0; i < 500; i++) begin
        prng = {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};
        step(prng[1:0] == 2'b10 ? 2'b00 : prng[1:0]);
      end
    end
    chk(byp_cnt >= 97 && byp_cnt <= 99, "R9 R1 group cadence", byp_cnt, 98);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule